// File: doc/BRIEF.md
# Indirect-Access Statistics Counter Bank

This block keeps one 24-bit event counter for every statistics source of a multi-port cell interface. Each port has nine sources: four ingress cell events, two transmit-link events and three receive-link events. With the default sixteen ports that makes 144 counters. Each counter advances on a single-cycle strobe. When a counter passes all ones it wraps to zero and sets a sticky overflow flag. The flags drive one interrupt line, and each flag can be masked on its own.

Software never addresses a counter directly. It works through a five-register window: two data registers that hold a 24-bit value, a select register, a command register, and a flag/mask register for the selected counter. A read command copies the selected counter into the data registers, and that copy stays frozen until the next read. A preload stages a value in the data registers and then loads it into the selected counter, so the interrupt can fire after a chosen number of events. A latch command copies every counter into a snapshot bank in the same cycle, which gives a coherent set of values that can be read back later.

Top module: `stat_bank`

## Requirements
- R1: Each counter is 24 bits wide and adds 1 on every clock edge at which its strobe is high. A strobe while the counter holds 0xFFFFFF wraps it to 0 and sets that counter's overflow flag at the same edge.
- R2: Synchronous reset (rst high) clears all counters, all snapshots, all overflow flags and both data registers, and sets every mask bit.
- R3: `irq` is registered. It goes high one clock after an unmasked overflow flag is set, and it stays low while no flag is set.
- R4: Each counter has a mask bit. A write to address 4 copies wr_data bit 1 into the selected counter's mask bit. A masked flag is still recorded, and a read of address 4 returns it in bit 0 with the mask in bit 1.
- R5: Command code 3'b010 copies every counter into its snapshot at one edge. Command code 3'b111 then copies the selected counter's snapshot into the data registers.
- R6: Command code 3'b101 copies the selected live counter into the data registers. Address 0 returns bits 23:16 in its low byte, and address 1 returns bits 15:0.
- R7: The data registers do not change except on an accepted read command or a software write to address 0 or 1. Counting does not alter them.
- R8: A preload takes three steps: write the value to addresses 0 and 1, write the index to address 2, then write command code 3'b001 to address 3. The selected counter then holds the staged value.
- R9: Only wr_data bits 2:0 of a command are decoded. Other codes are ignored. Read, write and flag commands are also ignored when the select register holds an index of 144 or more.
- R10: Receive-link counters (slots 6 to 8) count only while that port's `rx_en` bit is high.
- R11: Counter index = port*9 + slot. Slots 0-3 are ingress, 4-5 are transmit link, and 6-8 are receive link. `ev` bit i strobes counter i.
- R12: When a preload and an event hit the same counter at the same edge, the preload value is stored and the event is lost.
- R13: Writing address 4 with bit 0 set clears the selected overflow flag. A wrap at the same edge overrides the clear.
- R14: `rd_data` is registered: it shows the register named by `rd_addr` one clock after that address is sampled. Address 2 returns the select value and address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Registered read data |
| ev | input | 144 | Event strobes, one per counter |
| rx_en | input | 16 | Per-port receive-link enable |
| irq | output | 1 | OR of unmasked overflow flags, registered |

## Verification
A register write takes effect at the first rising edge after it is driven. A counter, data register, snapshot or flag therefore changes at that edge, `rd_data` reflects it one edge later, and `irq` follows an overflow flag by one further edge. The bench drives all inputs on falling edges. Each read task pushes its expected word into a queue just after the rising edge that loads `rd_data`, and a monitor pops and compares the word at the following falling edge. The interrupt is sampled on the falling edge two edges after the wrapping strobe.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int DW = 16;
  localparam int AW = 3;

  localparam int N_ING   = 4;
  localparam int N_TX    = 2;
  localparam int N_RX    = 3;
  localparam int N_SLOT  = N_ING + N_TX + N_RX;
  localparam int RX_BASE = N_ING + N_TX;

  localparam logic [AW-1:0] A_HI  = 3'd0;
  localparam logic [AW-1:0] A_LO  = 3'd1;
  localparam logic [AW-1:0] A_SEL = 3'd2;
  localparam logic [AW-1:0] A_CMD = 3'd3;
  localparam logic [AW-1:0] A_OVF = 3'd4;

  typedef enum logic [2:0] {
    CMD_WRITE     = 3'b001,
    CMD_LATCH     = 3'b010,
    CMD_READ      = 3'b101,
    CMD_READ_SNAP = 3'b111
  } cmd_t;
endpackage

// File: rtl/stat_cell.sv
module stat_cell #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  input  logic          snap,
  input  logic          clr,
  input  logic          mwr,
  input  logic          mval,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] snap_q,
  output logic          ovf_q,
  output logic          msk_q
);
  logic wrap;
  assign wrap = ev && !ld && (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      snap_q <= '0;
      ovf_q  <= 1'b0;
      msk_q  <= 1'b1;
    end else begin
      if (ld)      cnt_q <= ld_val;
      else if (ev) cnt_q <= cnt_q + 1'b1;
      if (snap) snap_q <= cnt_q;
      if (wrap)     ovf_q <= 1'b1;
      else if (clr) ovf_q <= 1'b0;
      if (mwr) msk_q <= mval;
    end
  end
endmodule

// File: rtl/stat_window.sv
module stat_window
  import stat_pkg::*;
#(
  parameter int CW   = 24,
  parameter int NCNT = 144,
  parameter int SW   = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  input  logic [CW-1:0] live_val,
  input  logic [CW-1:0] snap_val,
  input  logic          ovf_sel,
  input  logic          msk_sel,
  output logic [SW-1:0] sel_q,
  output logic          sel_ok,
  output logic [CW-1:0] hold_q,
  output logic          ld_go,
  output logic          rd_go,
  output logic          snap_go,
  output logic          clr_go,
  output logic          mwr_go,
  output logic          mval,
  output logic          stage_wr,
  output logic          sel_wr,
  output logic [DW-1:0] rd_data
);
  localparam int HW = CW - DW;

  logic [HW-1:0] hold_hi;
  logic [DW-1:0] hold_lo;
  logic          is_cmd;
  logic          rd_snap;
  cmd_t          cmd;

  always_comb begin
    cmd      = cmd_t'(wr_data[2:0]);
    sel_ok   = (int'(sel_q) < NCNT);
    is_cmd   = wr_en && (wr_addr == A_CMD);
    ld_go    = is_cmd && sel_ok && (cmd == CMD_WRITE);
    rd_go    = is_cmd && sel_ok && ((cmd == CMD_READ) || (cmd == CMD_READ_SNAP));
    rd_snap  = (cmd == CMD_READ_SNAP);
    snap_go  = is_cmd && (cmd == CMD_LATCH);
    mwr_go   = wr_en && (wr_addr == A_OVF) && sel_ok;
    clr_go   = mwr_go && wr_data[0];
    mval     = wr_data[1];
    stage_wr = wr_en && ((wr_addr == A_HI) || (wr_addr == A_LO));
    sel_wr   = wr_en && (wr_addr == A_SEL);
  end

  assign hold_q = {hold_hi, hold_lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_hi <= '0;
      hold_lo <= '0;
      sel_q   <= '0;
    end else begin
      if (rd_go) begin
        {hold_hi, hold_lo} <= rd_snap ? snap_val : live_val;
      end else if (wr_en && wr_addr == A_HI) begin
        hold_hi <= wr_data[HW-1:0];
      end else if (wr_en && wr_addr == A_LO) begin
        hold_lo <= wr_data;
      end
      if (sel_wr) sel_q <= wr_data[SW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        A_HI:    rd_data <= DW'(hold_hi);
        A_LO:    rd_data <= hold_lo;
        A_SEL:   rd_data <= DW'(sel_q);
        A_OVF:   rd_data <= DW'({msk_sel, ovf_sel});
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/stat_bank.sv
module stat_bank
  import stat_pkg::*;
#(
  parameter int NPORT = 16,
  parameter int CW    = 24,
  localparam int NCNT = NPORT * N_SLOT,
  localparam int SW   = $clog2(NCNT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic [NCNT-1:0]  ev,
  input  logic [NPORT-1:0] rx_en,
  output logic             irq
);
  logic [CW-1:0]   cnt_all [NCNT];
  logic [CW-1:0]   snp_all [NCNT];
  logic [NCNT-1:0] ovf_v, msk_v, ev_g;
  logic [SW-1:0]   sel_q;
  logic            sel_ok, ld_go, rd_go, snap_go, clr_go, mwr_go, mval;
  logic            stage_wr, sel_wr;
  logic [CW-1:0]   hold_q, live_val, snap_val;
  logic            ovf_sel, msk_sel, sel_ev;

  always_comb begin
    live_val = '0;
    snap_val = '0;
    ovf_sel  = 1'b0;
    msk_sel  = 1'b0;
    sel_ev   = 1'b0;
    if (sel_ok) begin
      live_val = cnt_all[sel_q];
      snap_val = snp_all[sel_q];
      ovf_sel  = ovf_v[sel_q];
      msk_sel  = msk_v[sel_q];
      sel_ev   = ev_g[sel_q];
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
      localparam int IDX = p * N_SLOT + s;
      logic hit;
      if (s >= RX_BASE) begin : g_rx
        assign ev_g[IDX] = ev[IDX] && rx_en[p];
      end else begin : g_plain
        assign ev_g[IDX] = ev[IDX];
      end
      assign hit = (sel_q == SW'(IDX));
      stat_cell #(.CW(CW)) u_cell (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev_g[IDX]),
        .ld     (ld_go && hit),
        .ld_val (hold_q),
        .snap   (snap_go),
        .clr    (clr_go && hit),
        .mwr    (mwr_go && hit),
        .mval   (mval),
        .cnt_q  (cnt_all[IDX]),
        .snap_q (snp_all[IDX]),
        .ovf_q  (ovf_v[IDX]),
        .msk_q  (msk_v[IDX])
      );
    end
  end

  stat_window #(.CW(CW), .NCNT(NCNT), .SW(SW)) u_win (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .live_val (live_val),
    .snap_val (snap_val),
    .ovf_sel  (ovf_sel),
    .msk_sel  (msk_sel),
    .sel_q    (sel_q),
    .sel_ok   (sel_ok),
    .hold_q   (hold_q),
    .ld_go    (ld_go),
    .rd_go    (rd_go),
    .snap_go  (snap_go),
    .clr_go   (clr_go),
    .mwr_go   (mwr_go),
    .mval     (mval),
    .stage_wr (stage_wr),
    .sel_wr   (sel_wr),
    .rd_data  (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(ovf_v & ~msk_v);
  end
endmodule

// File: rtl/stat_bank_chk.sv
module stat_bank_chk #(
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          irq,
  input logic          ovf_any,
  input logic [CW-1:0] hold,
  input logic [CW-1:0] live_val,
  input logic [CW-1:0] ld_val,
  input logic          rd_go,
  input logic          stage_wr,
  input logic          ld_go,
  input logic          sel_ev,
  input logic          sel_wr
);
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sel_ev && (&live_val) && !ld_go && !sel_wr) |=> (live_val == '0)); // R1
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (live_val == '0)); // R2
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    !$past(ovf_any) |-> !irq); // R3
  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!rd_go && !stage_wr) |=> $stable(hold)); // R7
  AST_PRELOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    ld_go |=> (live_val == $past(ld_val))); // R12
endmodule

bind stat_bank stat_bank_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq      (irq),
  .ovf_any  (|ovf_v),
  .hold     (hold_q),
  .live_val (live_val),
  .ld_val   (hold_q),
  .rd_go    (rd_go),
  .stage_wr (stage_wr),
  .ld_go    (ld_go),
  .sel_ev   (sel_ev),
  .sel_wr   (sel_wr)
);

// File: tb/sim_stat_bank.sv
`timescale 1ns/1ps
module sim_stat_bank;
  localparam int NP = 16;
  localparam int NC = NP * 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic [2:0]    rd_addr = '0;
  logic [15:0]   rd_data;
  logic [NC-1:0] ev = '0;
  logic [NP-1:0] rx_en = '1;
  logic          irq;

  int total = 0;
  int bad   = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  stat_bank u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ev(ev), .rx_en(rx_en), .irq(irq)
  );

  // monitor: compares each due read result at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (rd_data !== e) begin
        bad++;
        $display("FAIL %s rd_data got=%h exp=%h", t, rd_data, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    rd_addr = a;
    @(posedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic pulse(input int idx, input int n);
    @(negedge clk);
    ev[idx] = 1'b1;
    repeat (n) @(negedge clk);
    ev[idx] = 1'b0;
  endtask

  task automatic read_cnt(input int idx, input bit snap, input logic [23:0] e, input string t);
    wr(3'd2, 16'(idx));
    wr(3'd3, snap ? 16'h7 : 16'h5);
    rd_chk(3'd0, {8'h00, e[23:16]}, t);
    rd_chk(3'd1, e[15:0], t);
  endtask

  task automatic preload(input int idx, input logic [23:0] v);
    wr(3'd0, {8'h00, v[23:16]});
    wr(3'd1, v[15:0]);
    wr(3'd2, 16'(idx));
    wr(3'd3, 16'h1);
  endtask

  task automatic chk_bit(input logic got, input logic e, input string t);
    total++;
    if (got !== e) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", t, got, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all-reqs got=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R2 reset state
    chk_bit(irq, 1'b0, "R2 irq after reset");
    rd_chk(3'd0, 16'h0000, "R2 data hi reset");
    rd_chk(3'd1, 16'h0000, "R2 data lo reset");
    rd_chk(3'd4, 16'h0002, "R2 R4 mask set after reset");
    read_cnt(0, 1'b0, 24'd0, "R2 counter 0 reset");

    // R1 R6 counting and live read
    pulse(0, 5);
    read_cnt(0, 1'b0, 24'd5, "R1 R6 count of 5");
    // R7 hold frozen while counting
    pulse(0, 3);
    rd_chk(3'd1, 16'd5, "R7 hold unchanged");
    read_cnt(0, 1'b0, 24'd8, "R6 reread 8");
    rd_chk(3'd2, 16'd0, "R14 select readback");

    // R8 preload, split
    preload(10, 24'hAB1234);
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0000);
    read_cnt(10, 1'b0, 24'hAB1234, "R8 R6 preload split");

    // R1 R3 wrap and interrupt
    preload(20, 24'hFFFFFE);
    wr(3'd4, 16'h0000);
    pulse(20, 1);
    @(negedge clk);
    chk_bit(irq, 1'b0, "R3 no irq before wrap");
    pulse(20, 1);
    @(negedge clk);
    chk_bit(irq, 1'b1, "R3 irq after wrap");
    read_cnt(20, 1'b0, 24'd0, "R1 wrap to zero");
    rd_chk(3'd4, 16'h0001, "R1 R4 flag set unmasked");
    // R13 clear, re-mask
    wr(3'd4, 16'h0003);
    repeat (2) @(negedge clk);
    chk_bit(irq, 1'b0, "R13 irq after clear");
    rd_chk(3'd4, 16'h0002, "R13 flag cleared");

    // R4 masked overflow
    preload(21, 24'hFFFFFF);
    pulse(21, 1);
    repeat (2) @(negedge clk);
    chk_bit(irq, 1'b0, "R4 masked no irq");
    rd_chk(3'd4, 16'h0003, "R4 masked flag recorded");

    // R5 latch
    @(negedge clk);
    ev[30] = 1'b1; ev[31] = 1'b1;
    repeat (4) @(negedge clk);
    ev[30] = 1'b0; ev[31] = 1'b0;
    wr(3'd3, 16'h2);
    pulse(30, 2);
    read_cnt(30, 1'b1, 24'd4, "R5 snapshot 30");
    read_cnt(31, 1'b1, 24'd4, "R5 snapshot 31");
    read_cnt(30, 1'b0, 24'd6, "R5 live 30");

    // R10 receive gating, port 1 slot 6 = index 15
    rx_en[1] = 1'b0;
    pulse(15, 3);
    read_cnt(15, 1'b0, 24'd0, "R10 disabled rx");
    rx_en[1] = 1'b1;
    pulse(15, 2);
    read_cnt(15, 1'b0, 24'd2, "R10 enabled rx");

    // R11 mapping: port 2 slot 5 = index 23
    pulse(23, 3);
    read_cnt(23, 1'b0, 24'd3, "R11 index 23");
    read_cnt(22, 1'b0, 24'd0, "R11 neighbour 22");

    // R12 preload beats event
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'd100);
    wr(3'd2, 16'd40);
    @(negedge clk);
    ev[40] = 1'b1; wr_en = 1'b1; wr_addr = 3'd3; wr_data = 16'h1;
    @(negedge clk);
    ev[40] = 1'b0; wr_en = 1'b0;
    read_cnt(40, 1'b0, 24'd100, "R12 preload wins");

    // R9 ignored codes and out-of-range select
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0055);
    wr(3'd2, 16'd0);
    wr(3'd3, 16'h3);
    wr(3'd2, 16'd200);
    wr(3'd3, 16'h5);
    rd_chk(3'd1, 16'h0055, "R9 out-of-range read ignored");
    read_cnt(0, 1'b0, 24'd8, "R9 illegal code ignored");

    wait (exp_q.size() == 0);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule